// File: doc/BRIEF.md
# Shadow-aware physical register allocator

This block chooses the destination physical register for each instruction at rename. The physical register file is split into four banks. Each bank holds registers with a fixed number of shadow cells: zero, one, two or three. A register in a bank with shadow cells can take a new value in place while keeping its old value as a checkpoint. So the first allocator choice is to hand a source operand's own physical register back as the destination. This is allowed when nothing has read the source yet and the source still has an unused shadow cell.

When reuse is not possible, the allocator takes a register from the bank named by the predicted type. If that bank is empty, it takes one from the bank whose shadow-cell count is nearest to the predicted type. If every bank is empty, rename stalls. The block keeps three items per register: a read bit, a two-bit count of shadow cells in use, and the predictor index under which the register was allocated. On release, that index is returned so that the predictor can be trained elsewhere.

Top module: `shadow_reg_alloc`

## Requirements
- R1: A request with a valid source is granted the source register itself (`alloc_reused`=1, `alloc_preg`=source) exactly when the source's read bit is clear and its used-shadow count is below the capacity of its bank. The bank is bits [PREG_W-1:PREG_W-2] of the register ID, and bank number b has capacity b.
- R2: A source in bank 0 is never reused, whatever its read bit is.
- R3: Each reuse adds one to the source's used-shadow count. After a bank-b register has been reused b times in a row, the next request with that source gets a fresh register.
- R4: When a granted request has a valid source and does not reuse it, that source's read bit is set, and later requests never reuse it until it is released.
- R5: A fresh allocation takes the free register with the lowest index in the chosen bank and returns ID {bank, index}.
- R6: The chosen bank is the predicted type when that bank has a free register. Otherwise it is the non-empty bank with the smallest distance |bank − predicted|, and a tie goes to the bank with more shadow cells.
- R7: A request that neither reuses nor finds any free register raises `alloc_stall`, drops `alloc_gnt`, and changes no state.
- R8: A freshly allocated register starts with its read bit clear and a used count of 0. If its bank has shadow cells, it can be reused on the next request that names it.
- R9: Release puts the register back on its bank's free list and clears its used count. In the same cycle it drives `rel_train_vld` together with `rel_train_idx`, which is the predictor index given when the register was freshly allocated.
- R10: One allocation and one release can take effect in the same cycle. A register released in a cycle cannot be allocated until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; all registers are free |
| alloc_req | input | 1 | Rename needs a destination register this cycle |
| alloc_pred_type | input | 2 | Predicted shadow-cell count (bank) |
| alloc_pred_idx | input | PIDX_W | Predictor table index to store with a fresh register |
| alloc_src_vld | input | 1 | A source operand is offered for reuse |
| alloc_src_preg | input | PREG_W | Physical ID of the offered source |
| alloc_gnt | output | 1 | A destination was chosen this cycle |
| alloc_reused | output | 1 | The destination is the source register reused in place |
| alloc_preg | output | PREG_W | Chosen destination ID, 0 when not granted |
| alloc_stall | output | 1 | No reuse and no free register: rename must stall |
| rel_vld | input | 1 | A register is released this cycle |
| rel_preg | input | PREG_W | ID of the released register |
| rel_train_vld | output | 1 | Training record valid, follows rel_vld |
| rel_train_idx | output | PIDX_W | Stored predictor index of the released register |

## Verification
An allocation and a release can happen in the same cycle, and the two can collide on the free lists. The bench forces this in the all-banks-empty case: it releases a register in the same cycle as a request that must stall. The stall is expected to hold in that cycle, and the next request should receive exactly the released register. A long pseudo-random phase also mixes releases with reuses and fresh allocations in random cycles. Each output is compared against a bench model computed from the requirements, using a distance-cost formula for bank choice.

// File: rtl/spa_pkg.sv
package spa_pkg;

    localparam int NUM_TYPES = 4;

    typedef logic [1:0] rtype_t;

    typedef struct packed {
        logic   found;
        rtype_t ty;
    } tsel_t;

    // Nearest non-empty bank to the predicted one; ties favour the
    // bank with more shadow cells, so the upward candidate is tried first.
    function automatic tsel_t nearest_type(rtype_t pred, logic [NUM_TYPES-1:0] avail);
        tsel_t r;
        int    up;
        int    dn;
        r = '0;
        for (int d = 0; d < NUM_TYPES; d++) begin
            up = int'(pred) + d;
            dn = int'(pred) - d;
            if (!r.found) begin
                if (up < NUM_TYPES && avail[up[1:0]]) begin
                    r.found = 1'b1;
                    r.ty    = up[1:0];
                end else if (dn >= 0 && avail[dn[1:0]]) begin
                    r.found = 1'b1;
                    r.ty    = dn[1:0];
                end
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/spa_free_bank.sv
module spa_free_bank #(
    parameter  int BANK_REGS = 4,
    localparam int IDX_W     = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             rel,
    input  logic [IDX_W-1:0] rel_idx,
    output logic             any_free,
    output logic [IDX_W-1:0] pick_idx
);

    logic [BANK_REGS-1:0] free_q;
    logic [BANK_REGS-1:0] take_mask;
    logic [BANK_REGS-1:0] rel_mask;

    // Priority encoder: lowest free index wins.
    always_comb begin
        pick_idx = '0;
        for (int i = BANK_REGS - 1; i >= 0; i--) begin
            if (free_q[i]) pick_idx = IDX_W'(i);
        end
    end

    assign any_free  = |free_q;
    assign take_mask = take ? (BANK_REGS'(1) << pick_idx) : '0;
    assign rel_mask  = rel  ? (BANK_REGS'(1) << rel_idx)  : '0;

    always_ff @(posedge clk) begin
        if (rst) free_q <= '1;
        else     free_q <= (free_q & ~take_mask) | rel_mask;
    end

    AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        take && !(rel && rel_idx == pick_idx) |=> !free_q[$past(pick_idx)]); // R5
    AST_REL_SETS: assert property (@(posedge clk) disable iff (rst)
        rel |=> free_q[$past(rel_idx)]); // R9
    AST_REL_WAS_BUSY: assert property (@(posedge clk) disable iff (rst)
        rel |-> !free_q[rel_idx]); // R9

endmodule

// File: rtl/spa_reg_state.sv
module spa_reg_state #(
    parameter int PREG_W = 4,
    parameter int PIDX_W = 4,
    localparam int NREGS = 1 << PREG_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fresh_vld,
    input  logic [PREG_W-1:0] fresh_preg,
    input  logic [PIDX_W-1:0] fresh_pidx,
    input  logic              reuse_vld,
    input  logic [PREG_W-1:0] reuse_preg,
    input  logic              mark_vld,
    input  logic [PREG_W-1:0] mark_preg,
    input  logic              rel_vld,
    input  logic [PREG_W-1:0] rel_preg,
    input  logic [PREG_W-1:0] query_preg,
    output logic              query_read,
    output logic [1:0]        query_used,
    output logic [PIDX_W-1:0] rel_pidx
);

    logic              read_q [NREGS];
    logic [1:0]        used_q [NREGS];
    logic [PIDX_W-1:0] pidx_q [NREGS];

    assign query_read = read_q[query_preg];
    assign query_used = used_q[query_preg];
    assign rel_pidx   = pidx_q[rel_preg];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREGS; i++) begin
                read_q[i] <= 1'b0;
                used_q[i] <= 2'd0;
                pidx_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NREGS; i++) begin
                if (rel_vld && rel_preg == PREG_W'(i)) begin
                    used_q[i] <= 2'd0;
                    read_q[i] <= 1'b0;
                end
                if (fresh_vld && fresh_preg == PREG_W'(i)) begin
                    used_q[i] <= 2'd0;
                    read_q[i] <= 1'b0;
                    pidx_q[i] <= fresh_pidx;
                end
                if (reuse_vld && reuse_preg == PREG_W'(i))
                    used_q[i] <= used_q[i] + 2'd1;
                if (mark_vld && mark_preg == PREG_W'(i))
                    read_q[i] <= 1'b1;
            end
        end
    end

    AST_REUSE_INCR: assert property (@(posedge clk) disable iff (rst)
        reuse_vld && !(rel_vld && rel_preg == reuse_preg)
        |=> used_q[$past(reuse_preg)] == $past(used_q[reuse_preg]) + 2'd1); // R3
    AST_REUSE_UNDER_CAP: assert property (@(posedge clk) disable iff (rst)
        reuse_vld |-> used_q[reuse_preg] < reuse_preg[PREG_W-1 -: 2]); // R1
    AST_FRESH_CLEAN: assert property (@(posedge clk) disable iff (rst)
        fresh_vld |=> used_q[$past(fresh_preg)] == 2'd0 && !read_q[$past(fresh_preg)]); // R8
    AST_MARK_SETS: assert property (@(posedge clk) disable iff (rst)
        mark_vld && !(rel_vld && rel_preg == mark_preg) |=> read_q[$past(mark_preg)]); // R4

endmodule

// File: rtl/shadow_reg_alloc.sv
module shadow_reg_alloc
    import spa_pkg::*;
#(
    parameter  int BANK_REGS = 4,
    parameter  int PIDX_W    = 4,
    localparam int IDX_W     = (BANK_REGS > 1) ? $clog2(BANK_REGS) : 1,
    localparam int PREG_W    = IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc_req,
    input  logic [1:0]        alloc_pred_type,
    input  logic [PIDX_W-1:0] alloc_pred_idx,
    input  logic              alloc_src_vld,
    input  logic [PREG_W-1:0] alloc_src_preg,
    output logic              alloc_gnt,
    output logic              alloc_reused,
    output logic [PREG_W-1:0] alloc_preg,
    output logic              alloc_stall,
    input  logic              rel_vld,
    input  logic [PREG_W-1:0] rel_preg,
    output logic              rel_train_vld,
    output logic [PIDX_W-1:0] rel_train_idx
);

    logic [NUM_TYPES-1:0] avail;
    logic [NUM_TYPES-1:0] take;
    logic [NUM_TYPES-1:0] rel_hit;
    logic [IDX_W-1:0]     pick [NUM_TYPES];
    logic                 src_read;
    logic [1:0]           src_used;
    rtype_t               src_bank;
    tsel_t                sel;
    logic                 reuse_ok;
    logic                 fresh;
    logic [PREG_W-1:0]    fresh_preg;

    assign src_bank   = alloc_src_preg[PREG_W-1 -: 2];
    assign reuse_ok   = alloc_req && alloc_src_vld && !src_read && (src_used < src_bank);
    assign sel        = nearest_type(rtype_t'(alloc_pred_type), avail);
    assign fresh      = alloc_req && !reuse_ok && sel.found;
    assign fresh_preg = {sel.ty, pick[sel.ty]};

    assign alloc_gnt     = reuse_ok || fresh;
    assign alloc_reused  = reuse_ok;
    assign alloc_stall   = alloc_req && !reuse_ok && !sel.found;
    assign alloc_preg    = reuse_ok ? alloc_src_preg : (fresh ? fresh_preg : '0);
    assign rel_train_vld = rel_vld;

    for (genvar b = 0; b < NUM_TYPES; b++) begin : g_bank
        assign take[b]    = fresh && sel.ty == rtype_t'(b);
        assign rel_hit[b] = rel_vld && rel_preg[PREG_W-1 -: 2] == rtype_t'(b);
        spa_free_bank #(.BANK_REGS(BANK_REGS)) u_bank (
            .clk      (clk),
            .rst      (rst),
            .take     (take[b]),
            .rel      (rel_hit[b]),
            .rel_idx  (rel_preg[IDX_W-1:0]),
            .any_free (avail[b]),
            .pick_idx (pick[b])
        );
    end

    spa_reg_state #(.PREG_W(PREG_W), .PIDX_W(PIDX_W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .fresh_vld  (fresh),
        .fresh_preg (fresh_preg),
        .fresh_pidx (alloc_pred_idx),
        .reuse_vld  (reuse_ok),
        .reuse_preg (alloc_src_preg),
        .mark_vld   (fresh && alloc_src_vld),
        .mark_preg  (alloc_src_preg),
        .rel_vld    (rel_vld),
        .rel_preg   (rel_preg),
        .query_preg (alloc_src_preg),
        .query_read (src_read),
        .query_used (src_used),
        .rel_pidx   (rel_train_idx)
    );

    AST_REUSE_BANK: assert property (@(posedge clk) disable iff (rst)
        alloc_reused |-> alloc_preg[PREG_W-1 -: 2] != 2'd0); // R2
    AST_STALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        alloc_stall |-> avail == '0); // R7
    AST_GNT_XOR_STALL: assert property (@(posedge clk) disable iff (rst)
        alloc_req |-> (alloc_gnt ^ alloc_stall)); // R7
    AST_STALL_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
        alloc_stall && !rel_vld |=> avail == $past(avail)); // R7
    AST_FRESH_FROM_FREE: assert property (@(posedge clk) disable iff (rst)
        alloc_gnt && !alloc_reused |-> avail[alloc_preg[PREG_W-1 -: 2]]); // R6
    AST_ONE_TAKE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(take)); // R5
    AST_TRAIN_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        rel_train_vld == rel_vld); // R9

endmodule

// File: tb/shadow_reg_alloc_tb_top.sv
module shadow_reg_alloc_tb_top;

    localparam int BR     = 4;
    localparam int PIDX_W = 4;
    localparam int PREG_W = 4;
    localparam int NR     = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              alloc_req = 1'b0;
    logic [1:0]        alloc_pred_type = '0;
    logic [PIDX_W-1:0] alloc_pred_idx = '0;
    logic              alloc_src_vld = 1'b0;
    logic [PREG_W-1:0] alloc_src_preg = '0;
    logic              alloc_gnt, alloc_reused, alloc_stall, rel_train_vld;
    logic [PREG_W-1:0] alloc_preg;
    logic              rel_vld = 1'b0;
    logic [PREG_W-1:0] rel_preg = '0;
    logic [PIDX_W-1:0] rel_train_idx;

    always #10 clk = ~clk;

    shadow_reg_alloc #(.BANK_REGS(BR), .PIDX_W(PIDX_W)) dut_i (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    bit m_free [NR];
    bit m_rd   [NR];
    int m_used [NR];
    int m_pidx [NR];

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NR; i++) begin
            m_free[i] = 1; m_rd[i] = 0; m_used[i] = 0; m_pidx[i] = 0;
        end
    endtask

    task automatic reset_dut();
        @(negedge clk);
        rst = 1; alloc_req = 0; alloc_src_vld = 0; rel_vld = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
    endtask

    // One cycle: drive at negedge, compare before posedge, update model at posedge.
    task automatic cycle(bit req, int pt, int pi, bit sv, int sp, bit rv, int rp,
                         string ph, output int got);
        int  best, bcost, cost, sb, low;
        bit  reuse, egnt, estall;
        int  epreg;
        @(negedge clk);
        alloc_req = req; alloc_pred_type = 2'(pt); alloc_pred_idx = PIDX_W'(pi);
        alloc_src_vld = sv; alloc_src_preg = PREG_W'(sp);
        rel_vld = rv; rel_preg = PREG_W'(rp);
        #1;
        sb    = sp / BR;
        reuse = req && sv && !m_rd[sp] && (m_used[sp] < sb);
        best  = -1; bcost = 1000;
        for (int t = 0; t < 4; t++) begin
            bit any = 0;
            for (int k = 0; k < BR; k++) if (m_free[t*BR+k]) any = 1;
            cost = 2 * ((t > pt) ? t - pt : pt - t) + ((t < pt) ? 1 : 0);
            if (any && cost < bcost) begin best = t; bcost = cost; end
        end
        egnt   = req && (reuse || best >= 0);
        estall = req && !reuse && best < 0;
        epreg  = 0;
        if (reuse) epreg = sp;
        else if (egnt) begin
            low = -1;
            for (int k = BR - 1; k >= 0; k--) if (m_free[best*BR+k]) low = k;
            epreg = best * BR + low;
        end
        chk({ph, (sv ? " R1" : " R5")}, "gnt", int'(alloc_gnt), int'(egnt));
        chk({ph, " R1"}, "reused", int'(alloc_reused), int'(reuse));
        chk({ph, " R7"}, "stall", int'(alloc_stall), int'(estall));
        if (egnt) chk({ph, (reuse ? " R3" : " R6")}, "preg", int'(alloc_preg), epreg);
        chk({ph, " R9"}, "train_vld", int'(rel_train_vld), int'(rv));
        if (rv) chk({ph, " R9"}, "train_idx", int'(rel_train_idx), m_pidx[rp]);
        got = egnt ? epreg : -1;
        @(posedge clk);
        if (reuse) m_used[sp]++;
        else if (egnt) begin
            m_free[epreg] = 0; m_rd[epreg] = 0; m_used[epreg] = 0; m_pidx[epreg] = pi;
            if (sv) m_rd[sp] = 1;
        end
        if (rv) begin m_free[rp] = 1; m_used[rp] = 0; m_rd[rp] = 0; end
    endtask

    initial begin
        int g;
        reset_dut();
        // Reset state
        #1;
        chk("R5 reset", "gnt", int'(alloc_gnt), 0);
        chk("R7 reset", "stall", int'(alloc_stall), 0);

        // Sweep: every availability mask and every predicted bank (R5, R6, R7)
        for (int mask = 0; mask < 16; mask++) begin
            for (int p = 0; p < 4; p++) begin
                reset_dut();
                for (int b = 0; b < 4; b++)
                    if (!mask[b]) for (int k = 0; k < BR; k++)
                        cycle(1, b, b, 0, 0, 0, 0, "R6 drain", g);
                cycle(1, p, 7, 0, 0, 0, 0, "R6 sweep", g);
                if (mask == 0) begin
                    // R10: release during a stall is not visible until the next cycle
                    cycle(1, p, 5, 0, 0, 1, 2, "R10 stall+release", g);
                    cycle(1, p, 5, 0, 0, 0, 0, "R10 after release", g);
                    chk("R10", "preg", g, 2);
                end
            end
        end

        // Directed reuse chain in bank 3 (R1, R3, R4, R8)
        reset_dut();
        cycle(1, 3, 9, 0, 0, 0, 0, "R8 fresh", g);
        chk("R5", "first bank3 reg", g, 12);
        for (int n = 0; n < 3; n++) cycle(1, 0, 1, 1, 12, 0, 0, "R3 reuse", g);
        cycle(1, 0, 1, 1, 12, 0, 0, "R3 cap reached", g);
        chk("R3", "fresh after cap", g, 0);
        cycle(1, 3, 1, 1, 12, 0, 0, "R4 read bit", g);
        chk("R4", "no reuse once read", int'(g != 12), 1);
        // Bank 0 source never reused (R2)
        cycle(1, 1, 2, 1, 0, 0, 0, "R2 bank-zero source", g);
        chk("R2", "bank0 not reused", int'(g != 0), 1);
        // Fresh bank-1 register reusable at once (R8)
        cycle(1, 1, 4, 0, 0, 0, 0, "R8 fresh bank1", g);
        cycle(1, 0, 4, 1, g, 0, 0, "R8 reuse fresh", g);
        // Release returns stored index; reallocation gives a clean register (R9)
        cycle(0, 0, 0, 0, 0, 1, 12, "R9 release", g);
        cycle(1, 3, 6, 0, 0, 0, 0, "R9 realloc", g);
        chk("R9", "realloc same reg", g, 12);
        cycle(1, 0, 0, 1, 12, 0, 0, "R9 counter cleared", g);

        // Pseudo-random mix with same-cycle alloc/release (R10)
        reset_dut();
        for (int n = 0; n < 4000; n++) begin
            bit req, sv, rv;
            int sp, rp;
            req = ($urandom % 3) != 0;
            sp  = $urandom % NR;
            sv  = req && !m_free[sp] && ($urandom % 2);
            rp  = $urandom % NR;
            rv  = !m_free[rp] && !(sv && rp == sp) && ($urandom % 5 < 2);
            cycle(req, $urandom % 4, $urandom % 16, sv, sp, rv, rp, "R10 random", g);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R7 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule